// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block is the interlock and bypass controller of a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back) whose conditional branches evaluate both their condition and their target in decode. It is purely combinational. Each cycle it looks at the source registers of the instruction in decode and of the instruction in execute, and at the destination, write-enable and load flags carried by the three downstream pipeline registers. From these it decides whether the front of the pipe must freeze, which value each operand mux picks, and whether a taken branch must squash the instruction just fetched.

Two kinds of consumer need care. An ordinary instruction in execute can take a value from the memory-stage or write-back-stage latch, unless that value is still being loaded one slot ahead. A branch in decode compares its operands one stage earlier, so an arithmetic producer still in execute costs one lost cycle. A load producer costs two cycles if it is in execute and one cycle if it has reached memory. A producer already in write-back needs no help, because the register file is written in the first half of the cycle and read in the second.

The stall output freezes the program counter and the fetch/decode latch and zeroes the control bits entering the decode/execute latch. The flush output empties the fetch/decode latch for one cycle.

Top module: `hazardUnit`

## Requirements
- R1: When the instruction in decode reads a register (source index nonzero, use flag high) that a load in the decode/execute latch writes (regWrite and memRead high, same index), the stall condition is raised, whether or not the decode instruction is a branch.
- R2: Each execute-stage select is 2'b10 when the execute/memory latch writes a nonzero register equal to that used source. This holds even if the memory/write-back latch also matches. The code 2'b11 never appears.
- R3: Each execute-stage select is 2'b01 when only the memory/write-back latch writes a matching nonzero register. It is 2'b00 (register file) when neither latch matches.
- R4: A branch in decode that reads a register written by any instruction in the decode/execute latch raises the stall condition. A branch reading a register written by a non-load in the execute/memory latch gets decode select 2'b10 and no stall.
- R5: A branch in decode that reads a register written by a load in the execute/memory latch raises the stall condition, and its decode select stays 2'b00.
- R6: A producer that is only in the memory/write-back latch never raises a stall and never changes a decode select from 2'b00. The decode selects only ever take 2'b00 or 2'b10.
- R7: Register index 0 never matches as a producer: it causes no forward and no stall.
- R8: pcHold, ifidHold and idexBubble are always equal, and they are high exactly when a stall condition of R1, R4 or R5 holds.
- R9: ifidFlush is high exactly when decode holds a branch that is taken and no stall condition holds.
- R10: A source whose use flag is low, or a latch whose regWrite flag is low, takes part in no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idRs1 | input | IDX_W | First source index of the decode instruction |
| idRs2 | input | IDX_W | Second source index of the decode instruction |
| idUseRs1 | input | 1 | Decode instruction reads its first source |
| idUseRs2 | input | 1 | Decode instruction reads its second source |
| idIsBranch | input | 1 | Decode instruction is a conditional branch |
| idBranchTaken | input | 1 | Branch comparator reports taken |
| exRs1 | input | IDX_W | First source index of the execute instruction |
| exRs2 | input | IDX_W | Second source index of the execute instruction |
| exUseRs1 | input | 1 | Execute instruction reads its first source |
| exUseRs2 | input | 1 | Execute instruction reads its second source |
| idexDest | input | IDX_W | Destination held in the decode/execute latch |
| idexRegWrite | input | 1 | Decode/execute latch writes a register |
| idexMemRead | input | 1 | Decode/execute latch holds a load |
| exmemDest | input | IDX_W | Destination held in the execute/memory latch |
| exmemRegWrite | input | 1 | Execute/memory latch writes a register |
| exmemMemRead | input | 1 | Execute/memory latch holds a load |
| memwbDest | input | IDX_W | Destination held in the memory/write-back latch |
| memwbRegWrite | input | 1 | Memory/write-back latch writes a register |
| pcHold | output | 1 | Freeze the program counter |
| ifidHold | output | 1 | Freeze the fetch/decode latch |
| idexBubble | output | 1 | Zero control bits entering decode/execute |
| ifidFlush | output | 1 | Empty the fetch/decode latch |
| exFwdA | output | 2 | Select for execute ALU operand A |
| exFwdB | output | 2 | Select for execute ALU operand B |
| idFwdA | output | 2 | Select for branch comparator operand A |
| idFwdB | output | 2 | Select for branch comparator operand B |

## Verification
The checks assume that a latch flagged as a load also has its regWrite flag set, and that the taken flag is only meaningful with the branch flag. The random stimulus always sets regWrite together with memRead, and it draws register indices from a small range that includes zero, so that matches, double matches and zero-index producers occur often. Directed vectors walk a load through execute and then memory in front of a branch, to show the two-cycle interlock one cycle at a time.

// File: rtl/hazPkg.sv
package hazPkg;

  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_MEMWB   = 2'b01,
    SRC_EXMEM   = 2'b10
  } fwdSrc_e;

  // which downstream latch writes a given source operand
  typedef struct packed {
    logic inIdEx;
    logic inExMem;
    logic inMemWb;
  } prodHit_t;

  // strobes from the stall/flush control towards the pipeline
  typedef struct packed {
    logic holdPc;
    logic holdIfId;
    logic bubbleIdEx;
    logic flushIfId;
  } pipeStrobes_t;

  localparam int NUM_OPERANDS = 4;   // idA, idB, exA, exB
  localparam int OP_ID_A = 0;
  localparam int OP_ID_B = 1;
  localparam int OP_EX_A = 2;
  localparam int OP_EX_B = 3;

endpackage

// File: rtl/hazOperandMatch.sv
module hazOperandMatch
  import hazPkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] srcIdx,
  input  logic             srcUsed,
  input  logic [IDX_W-1:0] idexDest,
  input  logic             idexRegWrite,
  input  logic [IDX_W-1:0] exmemDest,
  input  logic             exmemRegWrite,
  input  logic [IDX_W-1:0] memwbDest,
  input  logic             memwbRegWrite,
  output prodHit_t         hit
);
  localparam logic [IDX_W-1:0] ZERO_REG = '0;

  logic srcLive;

  always_comb begin
    srcLive       = srcUsed && (srcIdx != ZERO_REG);
    hit.inIdEx    = srcLive && idexRegWrite  && (idexDest  == srcIdx);
    hit.inExMem   = srcLive && exmemRegWrite && (exmemDest == srcIdx);
    hit.inMemWb   = srcLive && memwbRegWrite && (memwbDest == srcIdx);
  end
endmodule

// File: rtl/hazStallCtrl.sv
module hazStallCtrl
  import hazPkg::*;
(
  input  prodHit_t     idHitA,
  input  prodHit_t     idHitB,
  input  logic         idexMemRead,
  input  logic         exmemMemRead,
  input  logic         idIsBranch,
  input  logic         idBranchTaken,
  output pipeStrobes_t strobes
);
  logic loadUse;
  logic branchOnExec;
  logic branchOnMemLoad;
  logic stallNow;

  always_comb begin
    // load one slot ahead of any decode consumer
    loadUse         = idexMemRead && (idHitA.inIdEx || idHitB.inIdEx);
    // branch compares in decode: any producer still in execute is too late
    branchOnExec    = idIsBranch && (idHitA.inIdEx || idHitB.inIdEx);
    // load data only exists at the end of the memory stage
    branchOnMemLoad = idIsBranch && exmemMemRead &&
                      (idHitA.inExMem || idHitB.inExMem);
    stallNow        = loadUse || branchOnExec || branchOnMemLoad;

    strobes.holdPc     = stallNow;
    strobes.holdIfId   = stallNow;
    strobes.bubbleIdEx = stallNow;
    strobes.flushIfId  = idIsBranch && idBranchTaken && !stallNow;
  end
endmodule

// File: rtl/hazFwdSelect.sv
module hazFwdSelect
  import hazPkg::*;
(
  input  prodHit_t hitIdA,
  input  prodHit_t hitIdB,
  input  prodHit_t hitExA,
  input  prodHit_t hitExB,
  input  logic     exmemMemRead,
  output fwdSrc_e  selIdA,
  output fwdSrc_e  selIdB,
  output fwdSrc_e  selExA,
  output fwdSrc_e  selExB
);
  function automatic fwdSrc_e pickExec(prodHit_t h);
    if (h.inExMem)      return SRC_EXMEM;   // youngest value wins
    else if (h.inMemWb) return SRC_MEMWB;
    else                return SRC_REGFILE;
  endfunction

  // write-back producers reach decode through the split-phase register file
  function automatic fwdSrc_e pickDecode(prodHit_t h, logic memIsLoad);
    if (h.inExMem && !memIsLoad) return SRC_EXMEM;
    else                         return SRC_REGFILE;
  endfunction

  always_comb begin
    selExA = pickExec(hitExA);
    selExB = pickExec(hitExB);
    selIdA = pickDecode(hitIdA, exmemMemRead);
    selIdB = pickDecode(hitIdB, exmemMemRead);
  end
endmodule

// File: rtl/hazardUnit.sv
module hazardUnit
  import hazPkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] idRs1,
  input  logic [IDX_W-1:0] idRs2,
  input  logic             idUseRs1,
  input  logic             idUseRs2,
  input  logic             idIsBranch,
  input  logic             idBranchTaken,
  input  logic [IDX_W-1:0] exRs1,
  input  logic [IDX_W-1:0] exRs2,
  input  logic             exUseRs1,
  input  logic             exUseRs2,
  input  logic [IDX_W-1:0] idexDest,
  input  logic             idexRegWrite,
  input  logic             idexMemRead,
  input  logic [IDX_W-1:0] exmemDest,
  input  logic             exmemRegWrite,
  input  logic             exmemMemRead,
  input  logic [IDX_W-1:0] memwbDest,
  input  logic             memwbRegWrite,
  output logic             pcHold,
  output logic             ifidHold,
  output logic             idexBubble,
  output logic             ifidFlush,
  output logic [1:0]       exFwdA,
  output logic [1:0]       exFwdB,
  output logic [1:0]       idFwdA,
  output logic [1:0]       idFwdB
);
  logic [IDX_W-1:0] srcIdx  [NUM_OPERANDS];
  logic             srcUsed [NUM_OPERANDS];
  prodHit_t         hits    [NUM_OPERANDS];
  pipeStrobes_t     strobes;
  fwdSrc_e          selIdA, selIdB, selExA, selExB;

  always_comb begin
    srcIdx[OP_ID_A]  = idRs1;   srcUsed[OP_ID_A] = idUseRs1;
    srcIdx[OP_ID_B]  = idRs2;   srcUsed[OP_ID_B] = idUseRs2;
    srcIdx[OP_EX_A]  = exRs1;   srcUsed[OP_EX_A] = exUseRs1;
    srcIdx[OP_EX_B]  = exRs2;   srcUsed[OP_EX_B] = exUseRs2;
  end

  for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_match
    hazOperandMatch #(.IDX_W(IDX_W)) i_match (
      .srcIdx        (srcIdx[g]),
      .srcUsed       (srcUsed[g]),
      .idexDest      (idexDest),
      .idexRegWrite  (idexRegWrite),
      .exmemDest     (exmemDest),
      .exmemRegWrite (exmemRegWrite),
      .memwbDest     (memwbDest),
      .memwbRegWrite (memwbRegWrite),
      .hit           (hits[g])
    );
  end

  hazStallCtrl i_stall (
    .idHitA        (hits[OP_ID_A]),
    .idHitB        (hits[OP_ID_B]),
    .idexMemRead   (idexMemRead),
    .exmemMemRead  (exmemMemRead),
    .idIsBranch    (idIsBranch),
    .idBranchTaken (idBranchTaken),
    .strobes       (strobes)
  );

  hazFwdSelect i_fwd (
    .hitIdA       (hits[OP_ID_A]),
    .hitIdB       (hits[OP_ID_B]),
    .hitExA       (hits[OP_EX_A]),
    .hitExB       (hits[OP_EX_B]),
    .exmemMemRead (exmemMemRead),
    .selIdA       (selIdA),
    .selIdB       (selIdB),
    .selExA       (selExA),
    .selExB       (selExB)
  );

  assign pcHold     = strobes.holdPc;
  assign ifidHold   = strobes.holdIfId;
  assign idexBubble = strobes.bubbleIdEx;
  assign ifidFlush  = strobes.flushIfId;
  assign exFwdA     = selExA;
  assign exFwdB     = selExB;
  assign idFwdA     = selIdA;
  assign idFwdB     = selIdB;
endmodule

// File: rtl/hazardUnitChk.sv
module hazardUnitChk #(
  parameter int IDX_W = 5
) (
  input logic [IDX_W-1:0] idRs1,
  input logic [IDX_W-1:0] idRs2,
  input logic             idUseRs1,
  input logic             idUseRs2,
  input logic             idIsBranch,
  input logic             idBranchTaken,
  input logic [IDX_W-1:0] exRs1,
  input logic [IDX_W-1:0] exRs2,
  input logic             exUseRs1,
  input logic             exUseRs2,
  input logic [IDX_W-1:0] idexDest,
  input logic             idexRegWrite,
  input logic             idexMemRead,
  input logic [IDX_W-1:0] exmemDest,
  input logic             exmemRegWrite,
  input logic             exmemMemRead,
  input logic [IDX_W-1:0] memwbDest,
  input logic             memwbRegWrite,
  input logic             pcHold,
  input logic             ifidHold,
  input logic             idexBubble,
  input logic             ifidFlush,
  input logic [1:0]       exFwdA,
  input logic [1:0]       exFwdB,
  input logic [1:0]       idFwdA,
  input logic [1:0]       idFwdB
);
  logic known;
  assign known = !$isunknown({idRs1, idRs2, idUseRs1, idUseRs2, idIsBranch,
                              idBranchTaken, exRs1, exRs2, exUseRs1, exUseRs2,
                              idexDest, idexRegWrite, idexMemRead, exmemDest,
                              exmemRegWrite, exmemMemRead, memwbDest,
                              memwbRegWrite});

  always_comb begin
    if (known) begin
      // R8
      stall_group_chk: assert (pcHold == ifidHold && ifidHold == idexBubble)
        else $error("stall strobes disagree");
      // R9
      flush_vs_stall_chk: assert (!(ifidFlush && pcHold))
        else $error("flush raised during stall");
      // R9
      flush_cause_chk: assert (!ifidFlush || (idIsBranch && idBranchTaken))
        else $error("flush without taken branch");
      // R2
      ex_code_legal_chk: assert (exFwdA != 2'b11 && exFwdB != 2'b11)
        else $error("illegal execute select");
      // R2
      ex_exmem_cause_chk: assert (exFwdA != 2'b10 ||
                                  (exmemRegWrite && exUseRs1 && exmemDest == exRs1))
        else $error("execute forward without producer");
      // R6
      id_code_legal_chk: assert (idFwdA[0] == 1'b0 && idFwdB[0] == 1'b0)
        else $error("decode select from write-back");
      // R7
      zero_no_stall_chk: assert (!pcHold || idexDest != '0 || exmemDest != '0)
        else $error("stall caused by register zero");
      // R1
      plain_stall_load_chk: assert (!pcHold || idIsBranch || idexMemRead)
        else $error("non-branch stall without load");
    end
  end
endmodule

bind hazardUnit hazardUnitChk #(.IDX_W(IDX_W)) i_hazardUnitChk (.*);

// File: tb/test_hazardUnit.sv
module test_hazardUnit;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 5;

  typedef struct packed {
    logic [IDX_W-1:0] idRs1, idRs2;
    logic             idUse1, idUse2, isBr, taken;
    logic [IDX_W-1:0] exRs1, exRs2;
    logic             exUse1, exUse2;
    logic [IDX_W-1:0] d1; logic w1, l1;
    logic [IDX_W-1:0] d2; logic w2, l2;
    logic [IDX_W-1:0] d3; logic w3;
  } stim_t;

  typedef struct packed {
    logic stall, flush;
    logic [1:0] exA, exB, idA, idB;
  } exp_t;

  logic clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;
  int checks = 0, fails = 0;
  bit done = 0;
  stim_t s;

  logic pcHold, ifidHold, idexBubble, ifidFlush;
  logic [1:0] exFwdA, exFwdB, idFwdA, idFwdB;

  hazardUnit #(.IDX_W(IDX_W)) i_hazardUnit (
    .idRs1(s.idRs1), .idRs2(s.idRs2), .idUseRs1(s.idUse1), .idUseRs2(s.idUse2),
    .idIsBranch(s.isBr), .idBranchTaken(s.taken),
    .exRs1(s.exRs1), .exRs2(s.exRs2), .exUseRs1(s.exUse1), .exUseRs2(s.exUse2),
    .idexDest(s.d1), .idexRegWrite(s.w1), .idexMemRead(s.l1),
    .exmemDest(s.d2), .exmemRegWrite(s.w2), .exmemMemRead(s.l2),
    .memwbDest(s.d3), .memwbRegWrite(s.w3),
    .pcHold(pcHold), .ifidHold(ifidHold), .idexBubble(idexBubble),
    .ifidFlush(ifidFlush), .exFwdA(exFwdA), .exFwdB(exFwdB),
    .idFwdA(idFwdA), .idFwdB(idFwdB));

  function automatic bit writes(logic [IDX_W-1:0] dst, logic we,
                                logic [IDX_W-1:0] src, logic used);
    return used && we && dst != 0 && dst == src;
  endfunction

  function automatic exp_t model(stim_t v);
    exp_t e;
    bit inEx1, inEx2, inMem1, inMem2;
    inEx1  = writes(v.d1, v.w1, v.idRs1, v.idUse1);
    inEx2  = writes(v.d1, v.w1, v.idRs2, v.idUse2);
    inMem1 = writes(v.d2, v.w2, v.idRs1, v.idUse1);
    inMem2 = writes(v.d2, v.w2, v.idRs2, v.idUse2);
    e.stall = (v.l1 && (inEx1 || inEx2)) ||                    // R1
              (v.isBr && (inEx1 || inEx2)) ||                   // R4
              (v.isBr && v.l2 && (inMem1 || inMem2));           // R5
    e.flush = v.isBr && v.taken && !e.stall;                    // R9
    e.idA = (inMem1 && !v.l2) ? 2'b10 : 2'b00;
    e.idB = (inMem2 && !v.l2) ? 2'b10 : 2'b00;
    e.exA = writes(v.d2, v.w2, v.exRs1, v.exUse1) ? 2'b10 :
            writes(v.d3, v.w3, v.exRs1, v.exUse1) ? 2'b01 : 2'b00;
    e.exB = writes(v.d2, v.w2, v.exRs2, v.exUse2) ? 2'b10 :
            writes(v.d3, v.w3, v.exRs2, v.exUse2) ? 2'b01 : 2'b00;
    return e;
  endfunction

  task automatic check(string tag, string what, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic apply(stim_t v, string tag);
    exp_t e;
    @(posedge clk);
    s = v;
    @(negedge clk);
    e = model(v);
    check(tag, "stall pc", {1'b0, pcHold}, {1'b0, e.stall});
    check("R8", "stall ifid", {1'b0, ifidHold}, {1'b0, e.stall});
    check("R8", "bubble", {1'b0, idexBubble}, {1'b0, e.stall});
    check(tag, "flush", {1'b0, ifidFlush}, {1'b0, e.flush});
    check(tag, "exFwdA", exFwdA, e.exA);
    check(tag, "exFwdB", exFwdB, e.exB);
    check(tag, "idFwdA", idFwdA, e.idA);
    check(tag, "idFwdB", idFwdB, e.idB);
  endtask

  function automatic stim_t idle();
    stim_t v = '0;
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    stim_t v;
    s = idle();
    // reset state: nothing in flight
    apply(idle(), "R8");

    // R1: add after load, non-branch
    v = idle(); v.idRs1 = 3; v.idUse1 = 1; v.d1 = 3; v.w1 = 1; v.l1 = 1;
    apply(v, "R1");
    // R2: both latches write execute source, EX/MEM wins
    v = idle(); v.exRs1 = 6; v.exUse1 = 1; v.exRs2 = 6; v.exUse2 = 1;
    v.d2 = 6; v.w2 = 1; v.d3 = 6; v.w3 = 1;
    apply(v, "R2");
    // R3: only MEM/WB matches
    v = idle(); v.exRs2 = 9; v.exUse2 = 1; v.d3 = 9; v.w3 = 1;
    apply(v, "R3");
    // R4: branch after ALU op in execute, then one slot later
    v = idle(); v.isBr = 1; v.taken = 1; v.idRs2 = 4; v.idUse2 = 1;
    v.d1 = 4; v.w1 = 1;
    apply(v, "R4");
    v.d1 = 0; v.w1 = 0; v.d2 = 4; v.w2 = 1;
    apply(v, "R4");
    // R5: branch after load: execute, memory, then write-back
    v = idle(); v.isBr = 1; v.taken = 1; v.idRs1 = 4; v.idUse1 = 1;
    v.d1 = 4; v.w1 = 1; v.l1 = 1;
    apply(v, "R5");
    v.d1 = 0; v.w1 = 0; v.l1 = 0; v.d2 = 4; v.w2 = 1; v.l2 = 1;
    apply(v, "R5");
    v.d2 = 0; v.w2 = 0; v.l2 = 0; v.d3 = 4; v.w3 = 1;
    apply(v, "R6");
    // R7: register zero everywhere
    v = idle(); v.isBr = 1; v.idUse1 = 1; v.idUse2 = 1; v.exUse1 = 1;
    v.w1 = 1; v.l1 = 1; v.w2 = 1; v.w3 = 1;
    apply(v, "R7");
    // R9: not-taken branch, and taken branch with no hazard
    v = idle(); v.isBr = 1; v.taken = 0;
    apply(v, "R9");
    v.taken = 1;
    apply(v, "R9");
    // R10: unused sources and silent producers
    v = idle(); v.idRs1 = 5; v.exRs1 = 5; v.d1 = 5; v.w1 = 1; v.l1 = 1;
    v.d2 = 5; v.w2 = 1;
    apply(v, "R10");
    v = idle(); v.idRs1 = 5; v.idUse1 = 1; v.exRs1 = 5; v.exUse1 = 1; v.isBr = 1;
    v.d1 = 5; v.d2 = 5; v.d3 = 5;
    apply(v, "R10");

    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      v.idRs1 = IDX_W'($urandom_range(0, 3)); v.idRs2 = IDX_W'($urandom_range(0, 3));
      v.exRs1 = IDX_W'($urandom_range(0, 3)); v.exRs2 = IDX_W'($urandom_range(0, 3));
      v.d1 = IDX_W'($urandom_range(0, 3)); v.d2 = IDX_W'($urandom_range(0, 3));
      v.d3 = IDX_W'($urandom_range(0, 3));
      v.idUse1 = 1'($urandom); v.idUse2 = 1'($urandom);
      v.exUse1 = 1'($urandom); v.exUse2 = 1'($urandom);
      v.isBr = 1'($urandom); v.taken = v.isBr & 1'($urandom);
      v.l1 = 1'($urandom); v.w1 = v.l1 | 1'($urandom);
      v.l2 = 1'($urandom); v.w2 = v.l2 | 1'($urandom);
      v.w3 = 1'($urandom);
      apply(v, "R1/R4/R5 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule